// File: doc/BRIEF.md
# Prescaled Match Timer with Shadowed Compare Values

This block is a free-running up-counter with a programmable prescaler and four compare channels. A tick source (every clock in timer mode, or chosen edges of a synchronised external input in counter mode) feeds the prescaler. The prescaler steps the main counter once every (prescale value + 1) ticks. Each channel compares its match value with the counter. On an equal compare, and depending on its action bits, the channel can raise an interrupt flag, zero the counter, or halt counting. Each channel also drives a pin, which either toggles on every match or, in PWM mode, gives a level that depends on where the count sits relative to the match value.

Each channel keeps a second, shadow copy of its match value. When the shadow is enabled, that copy moves into the live match register every time the counter is forced to zero. Software can therefore change the period or duty cycle at any moment without tearing a cycle. All configuration goes through a simple single-cycle write port.

Top module: `pscl_match_timer`

## Requirements
- R1: While running and not held, each tick increments the prescale counter (`pre_count`). On a tick where the prescale counter already equals the prescale value (address 3), the counter takes an advance instead and the prescale counter returns to 0. In timer mode every clock is a tick.
- R2: Each advance adds one to `tmr_count`, wrapping modulo 2^CNT_W, unless a match action below overrides it.
- R3: Control register at address 0: bit 0 is run, bit 1 is hold. While hold is set, both counters are forced to 0 on every clock.
- R4: `match_pulse[i]` is high in exactly those cycles where an advance is taken while `tmr_count` equals match value i (address 8+i).
- R5: The action register sits at address 4, with four bits per channel starting at bit 4i. Bit 4i enables the interrupt, so the match sets `irq_flag[i]`. Writing 1s to address 5 clears the corresponding flags, but a match in the same cycle keeps its flag set.
- R6: Bit 4i+1 (reset) makes the advance load 0 instead of count+1. Bit 4i+2 (stop) clears run and leaves the count at the match value. If both are set, the count goes to 0 and run clears in the same cycle.
- R7: Bit 4i+3 enables shadowing. The match value i is then loaded from shadow i (address 12+i) whenever a reset-on-match fires or hold is active. A bus write to the match value in the same cycle wins.
- R8: Mode register at address 6. Bit 0 selects counter mode, bit 1 counts rising edges, bit 2 counts falling edges, and bit 3 picks `cnt_in[1]` over `cnt_in[0]`. A level change on the input that is present at clock edge k is counted at edge k+2.
- R9: With its PWM bit (address 7, bit i) clear, `ext_match[i]` toggles on each match event of channel i.
- R10: With its PWM bit set, `ext_match[i]` is low while `tmr_count` is below match value i and high when it is at or above it.
- R11: Bus writes take priority in the same cycle. A write to the counter (address 1) or prescale counter (address 2) replaces the increment, and a control write overrides a stop.
- R12: After reset, all counters, flags, pins and configuration are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| cnt_in | input | NUM_IN | External count inputs (asynchronous) |
| tmr_count | output | CNT_W | Main counter value |
| pre_count | output | CNT_W | Prescale counter value |
| run | output | 1 | Run bit as currently held |
| match_pulse | output | NUM_CH | Per-channel match event |
| ext_match | output | NUM_CH | Per-channel match pin |
| irq_flag | output | NUM_CH | Per-channel sticky interrupt flag |

## Verification
A wrong prescaler or counter state shows up on `tmr_count` or `pre_count` in the very next cycle, because both are visible every clock. A wrong match value, such as a shadow reload that was missed or taken twice, stays hidden until the count reaches the intended compare point. From there it shifts the next `match_pulse`, and with it the period and the pin edges, so it appears within one period. A corrupted toggle state or interrupt flag is sticky and stays wrong on `ext_match` and `irq_flag` until the next event of that channel.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PCNT = 4'd2;
    localparam logic [ADDR_W-1:0] A_PSCL = 4'd3;
    localparam logic [ADDR_W-1:0] A_ACT  = 4'd4;
    localparam logic [ADDR_W-1:0] A_ICLR = 4'd5;
    localparam logic [ADDR_W-1:0] A_MODE = 4'd6;
    localparam logic [ADDR_W-1:0] A_PWM  = 4'd7;
    localparam int               A_MR0  = 8;
    localparam int               A_SH0  = 12;

    localparam int ACT_IRQ  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_STOP = 2;
    localparam int ACT_SHD  = 3;
    localparam int ACT_W    = 4;

    localparam int MODE_CNT  = 0;
    localparam int MODE_RISE = 1;
    localparam int MODE_FALL = 2;
    localparam int MODE_SEL  = 3;
endpackage

// File: rtl/mt_in_sync.sv
module mt_in_sync #(
    parameter int NUM_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] din,
    output logic [NUM_IN-1:0] rise,
    output logic [NUM_IN-1:0] fall
);
    typedef struct packed {
        logic [NUM_IN-1:0] s1;
        logic [NUM_IN-1:0] s2;
        logic [NUM_IN-1:0] s3;
    } sync_t;

    sync_t sy_q, sy_d;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise = sy_q.s2 & ~sy_q.s3;
    assign fall = ~sy_q.s2 & sy_q.s3;
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mr_we,
    input  logic             sh_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             reload,
    input  logic             shd_en,
    input  logic             pwm_en,
    input  logic [CNT_W-1:0] tmr,
    input  logic             adv,
    output logic             hit,
    output logic             pin
);
    typedef struct packed {
        logic [CNT_W-1:0] mr;
        logic [CNT_W-1:0] sh;
        logic             tog;
    } chan_t;

    chan_t ch_q, ch_d;

    assign hit = adv && (tmr == ch_q.mr);

    always_comb begin
        ch_d = ch_q;
        if (hit)              ch_d.tog = ~ch_q.tog;
        if (reload && shd_en) ch_d.mr  = ch_q.sh;
        if (mr_we)            ch_d.mr  = wdata;
        if (sh_we)            ch_d.sh  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign pin = pwm_en ? (tmr >= ch_q.mr) : ch_q.tog;
endmodule

// File: rtl/pscl_match_timer.sv
module pscl_match_timer
    import mt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 4,
    parameter int NUM_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NUM_IN-1:0] cnt_in,
    output logic [CNT_W-1:0]  tmr_count,
    output logic [CNT_W-1:0]  pre_count,
    output logic              run,
    output logic [NUM_CH-1:0] match_pulse,
    output logic [NUM_CH-1:0] ext_match,
    output logic [NUM_CH-1:0] irq_flag
);
    localparam int SEL_W   = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int ACT_TOT = NUM_CH * ACT_W;

    typedef struct packed {
        logic               run;
        logic               hold;
        logic [CNT_W-1:0]   tmr;
        logic [CNT_W-1:0]   pre;
        logic [CNT_W-1:0]   psc;
        logic [ACT_TOT-1:0] act;
        logic [NUM_CH-1:0]  pwm;
        logic               cmode;
        logic               rise_en;
        logic               fall_en;
        logic [SEL_W-1:0]   sel;
        logic [NUM_CH-1:0]  irq;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    logic [NUM_IN-1:0] in_rise, in_fall;
    logic              sel_rise, sel_fall;
    logic              tick, adv, reload, any_rst, any_stop;
    logic [NUM_CH-1:0] hit, irq_m, rst_m, stop_m, shd_m;

    mt_in_sync #(.NUM_IN(NUM_IN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cnt_in),
        .rise (in_rise),
        .fall (in_fall)
    );

    always_comb begin
        sel_rise = 1'b0;
        sel_fall = 1'b0;
        for (int k = 0; k < NUM_IN; k++) begin
            if (SEL_W'(k) == st_q.sel) begin
                sel_rise = in_rise[k];
                sel_fall = in_fall[k];
            end
        end
    end

    assign tick = !st_q.cmode || (st_q.rise_en && sel_rise) || (st_q.fall_en && sel_fall);
    assign adv  = st_q.run && !st_q.hold && tick && (st_q.pre == st_q.psc);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign irq_m[i]  = st_q.act[i*ACT_W + ACT_IRQ];
        assign rst_m[i]  = st_q.act[i*ACT_W + ACT_RST];
        assign stop_m[i] = st_q.act[i*ACT_W + ACT_STOP];
        assign shd_m[i]  = st_q.act[i*ACT_W + ACT_SHD];

        mt_match_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .mr_we (wr_en && (wr_addr == ADDR_W'(A_MR0 + i))),
            .sh_we (wr_en && (wr_addr == ADDR_W'(A_SH0 + i))),
            .wdata (wr_data),
            .reload(reload),
            .shd_en(shd_m[i]),
            .pwm_en(st_q.pwm[i]),
            .tmr   (st_q.tmr),
            .adv   (adv),
            .hit   (hit[i]),
            .pin   (ext_match[i])
        );
    end

    assign any_rst  = |(hit & rst_m);
    assign any_stop = |(hit & stop_m);
    assign reload   = st_q.hold || any_rst;

    always_comb begin
        st_d = st_q;

        // counting path
        if (st_q.hold) begin
            st_d.tmr = '0;
            st_d.pre = '0;
        end else if (st_q.run && tick) begin
            if (st_q.pre == st_q.psc) begin
                st_d.pre = '0;
                if (any_rst)        st_d.tmr = '0;
                else if (!any_stop) st_d.tmr = st_q.tmr + 1'b1;
                if (any_stop)       st_d.run = 1'b0;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end

        st_d.irq = st_q.irq | (hit & irq_m);

        // bus writes override the counting path
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.run  = wr_data[0];
                    st_d.hold = wr_data[1];
                end
                A_CNT:  st_d.tmr = wr_data;
                A_PCNT: st_d.pre = wr_data;
                A_PSCL: st_d.psc = wr_data;
                A_ACT:  st_d.act = wr_data[ACT_TOT-1:0];
                A_ICLR: st_d.irq = (st_q.irq & ~wr_data[NUM_CH-1:0]) | (hit & irq_m);
                A_MODE: begin
                    st_d.cmode   = wr_data[MODE_CNT];
                    st_d.rise_en = wr_data[MODE_RISE];
                    st_d.fall_en = wr_data[MODE_FALL];
                    st_d.sel     = wr_data[MODE_SEL +: SEL_W];
                end
                A_PWM:  st_d.pwm = wr_data[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_count   = st_q.tmr;
    assign pre_count   = st_q.pre;
    assign run         = st_q.run;
    assign irq_flag    = st_q.irq;
    assign match_pulse = hit;
endmodule

// File: rtl/pscl_match_timer_chk.sv
module pscl_match_timer_chk
    import mt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [CNT_W-1:0]        tmr_count,
    input logic [CNT_W-1:0]        pre_count,
    input logic                    run,
    input logic [NUM_CH-1:0]       match_pulse,
    input logic [NUM_CH-1:0]       ext_match,
    input logic [NUM_CH-1:0]       irq_flag,
    input logic                    hold_q,
    input logic [NUM_CH*ACT_W-1:0] act,
    input logic [NUM_CH-1:0]       pwm
);
    logic [NUM_CH-1:0] irq_m, rst_m, stop_m;
    logic cnt_wr, pcnt_wr, ctrl_wr, pwm_wr;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_m
        assign irq_m[i]  = act[i*ACT_W + ACT_IRQ];
        assign rst_m[i]  = act[i*ACT_W + ACT_RST];
        assign stop_m[i] = act[i*ACT_W + ACT_STOP];
    end

    assign cnt_wr  = wr_en && (wr_addr == A_CNT);
    assign pcnt_wr = wr_en && (wr_addr == A_PCNT);
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign pwm_wr  = wr_en && (wr_addr == A_PWM);

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q && !cnt_wr && !pcnt_wr |=> (tmr_count == '0) && (pre_count == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_count != $past(tmr_count)) |->
            (tmr_count == $past(tmr_count) + 1'b1) || (tmr_count == '0) || $past(cnt_wr));

    // R6
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_pulse & stop_m)) && !ctrl_wr |=> !run);

    // R6
    rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_pulse & rst_m)) && !cnt_wr |=> (tmr_count == '0));

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(match_pulse & irq_m)) |=> (($past(match_pulse & irq_m) & ~irq_flag) == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_tog
        // R9
        toggle_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_pulse[i] && !pwm[i] && !pwm_wr |=> (ext_match[i] != $past(ext_match[i])));
    end
endmodule

bind pscl_match_timer pscl_match_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .tmr_count  (tmr_count),
    .pre_count  (pre_count),
    .run        (run),
    .match_pulse(match_pulse),
    .ext_match  (ext_match),
    .irq_flag   (irq_flag),
    .hold_q     (st_q.hold),
    .act        (st_q.act),
    .pwm        (st_q.pwm)
);

// File: tb/pscl_match_timer_tb.sv
module pscl_match_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        w_en = 1'b0;
    logic [3:0]  w_addr = '0;
    logic [31:0] w_data = '0;
    logic [1:0]  cin = '0;
    logic [31:0] tmr_count, pre_count;
    logic        run;
    logic [3:0]  match_pulse, ext_match, irq_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    pscl_match_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
        .cnt_in(cin), .tmr_count(tmr_count), .pre_count(pre_count), .run(run),
        .match_pulse(match_pulse), .ext_match(ext_match), .irq_flag(irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic        m_run, m_hold;
    logic [31:0] m_tmr, m_pre, m_psc, m_act;
    logic [3:0]  m_pwm, m_mode, m_irq, m_tog;
    logic [31:0] m_mr [4];
    logic [31:0] m_sh [4];
    logic [1:0]  m_s1, m_s2, m_s3;

    task automatic mdl_reset();
        m_run = 0; m_hold = 0; m_tmr = 0; m_pre = 0; m_psc = 0; m_act = 0;
        m_pwm = 0; m_mode = 0; m_irq = 0; m_tog = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0;
        for (int i = 0; i < 4; i++) begin m_mr[i] = 0; m_sh[i] = 0; end
    endtask

    function automatic logic m_tick();
        int s = m_mode[3];
        logic r = m_s2[s] & ~m_s3[s];
        logic f = ~m_s2[s] & m_s3[s];
        return !m_mode[0] || (m_mode[1] && r) || (m_mode[2] && f);
    endfunction

    function automatic logic [3:0] m_hits();
        logic [3:0] h = '0;
        logic a = m_run && !m_hold && m_tick() && (m_pre == m_psc);
        for (int i = 0; i < 4; i++) h[i] = a && (m_tmr == m_mr[i]);
        return h;
    endfunction

    function automatic logic [3:0] m_pins();
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = m_pwm[i] ? (m_tmr >= m_mr[i]) : m_tog[i];
        return p;
    endfunction

    task automatic mdl_step();
        logic [3:0] h = m_hits();
        logic t = m_tick();
        logic rany = 0, sany = 0, rel;
        logic [3:0] iset = '0;
        for (int i = 0; i < 4; i++) begin
            if (h[i] && m_act[4*i+1]) rany = 1;
            if (h[i] && m_act[4*i+2]) sany = 1;
            if (h[i] && m_act[4*i])   iset[i] = 1;
        end
        rel = m_hold || rany;
        if (m_hold) begin
            m_tmr = 0; m_pre = 0;
        end else if (m_run && t) begin
            if (m_pre == m_psc) begin
                m_pre = 0;
                if (rany) m_tmr = 0;
                else if (!sany) m_tmr = m_tmr + 1;
                if (sany) m_run = 0;
            end else m_pre = m_pre + 1;
        end
        m_tog = m_tog ^ h;
        for (int i = 0; i < 4; i++) if (rel && m_act[4*i+3]) m_mr[i] = m_sh[i];
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = cin;
        if (w_en && w_addr == 5) m_irq = (m_irq & ~w_data[3:0]) | iset;
        else m_irq = m_irq | iset;
        if (w_en) begin
            case (w_addr)
                0: begin m_run = w_data[0]; m_hold = w_data[1]; end
                1: m_tmr = w_data;
                2: m_pre = w_data;
                3: m_psc = w_data;
                4: m_act = {16'h0, w_data[15:0]};
                6: m_mode = w_data[3:0];
                7: m_pwm = w_data[3:0];
                8, 9, 10, 11: m_mr[w_addr-8] = w_data;
                12, 13, 14, 15: m_sh[w_addr-12] = w_data;
                default: ;
            endcase
        end
    endtask

    initial mdl_reset();
    always @(posedge clk) begin
        if (!rst_n) mdl_reset();
        else mdl_step();
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R1 pre_count", pre_count, m_pre);
        chk("R2 tmr_count", tmr_count, m_tmr);
        chk("R6 run", {31'b0, run}, {31'b0, m_run});
        chk("R5 irq_flag", {28'b0, irq_flag}, {28'b0, m_irq});
        chk("R4 match_pulse", {28'b0, match_pulse}, {28'b0, m_hits()});
        chk("R9 R10 ext_match", {28'b0, ext_match}, {28'b0, m_pins()});
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        w_en = 1; w_addr = a; w_data = d;
        step();
        w_en = 0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        int first, second, cyc;
        step(); step();
        // R12 reset state
        chk("R12 tmr", tmr_count, 0);
        chk("R12 irq", {28'b0, irq_flag}, 0);
        chk("R12 pins", {28'b0, ext_match}, 0);
        chk("R12 run", {31'b0, run}, 0);
        rst_n = 1;
        step();

        // R1 prescale of 2
        wr(3, 2);
        wr(0, 1);
        repeat (20) step();

        // R4 R5 R9 R10: ch0 irq+reset at 5, ch1 irq at 3 in PWM mode
        wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
        wr(8, 5); wr(9, 3);
        wr(4, 32'h13);
        wr(7, 32'h2);
        wr(0, 1);
        repeat (30) step();

        // R6 stop on ch2 at 7
        wr(0, 0); wr(1, 0);
        wr(10, 7);
        wr(4, 32'h400);
        wr(0, 1);
        repeat (20) step();
        chk("R6 stop run", {31'b0, run}, 0);
        chk("R6 stop count", tmr_count, 7);
        chk("R6 stop pre", pre_count, 0);

        // R6 reset and stop together
        wr(1, 0);
        wr(4, 32'h600);
        wr(0, 1);
        repeat (20) step();
        chk("R6 both run", {31'b0, run}, 0);
        chk("R6 both count", tmr_count, 0);

        // R10 PWM level around match value 3
        wr(1, 2);
        chk("R10 below", {31'b0, ext_match[1]}, 0);
        wr(1, 3);
        chk("R10 at", {31'b0, ext_match[1]}, 1);

        // R7 shadow reload changes the period from 5 to 10
        wr(1, 0);
        wr(8, 4); wr(12, 9);
        wr(4, 32'hB);
        wr(0, 1);
        first = -1; second = -1;
        for (int k = 0; k < 40; k++) begin
            step();
            if (match_pulse[0]) begin
                if (first < 0) first = k;
                else if (second < 0) second = k;
            end
        end
        chk("R7 period", second - first, 10);

        // R5 clear flags while stopped
        wr(0, 0);
        wr(5, 32'hF);
        chk("R5 cleared", {28'b0, irq_flag}, 0);

        // R8 counter mode on input 0
        wr(4, 0); wr(1, 0); wr(2, 0);
        wr(6, 32'h3);
        wr(0, 1);
        cin = 2'b01; repeat (5) step();
        chk("R8 rise", tmr_count, 1);
        cin = 2'b00; repeat (5) step();
        chk("R8 rise only", tmr_count, 1);
        wr(6, 32'h5);
        cin = 2'b01; repeat (5) step();
        chk("R8 fall only", tmr_count, 1);
        cin = 2'b00; repeat (5) step();
        chk("R8 fall", tmr_count, 2);
        wr(6, 32'h7);
        cin = 2'b01; repeat (5) step();
        cin = 2'b00; repeat (5) step();
        chk("R8 both", tmr_count, 4);
        wr(6, 32'hF);
        cin = 2'b01; repeat (5) step();
        cin = 2'b00; repeat (5) step();
        chk("R8 other input ignored", tmr_count, 4);
        cin = 2'b10; repeat (5) step();
        chk("R8 input one", tmr_count, 5);
        wr(3, 1);
        for (int k = 0; k < 4; k++) begin
            cin = ~cin; repeat (4) step();
        end

        // R11 bus write wins over increment
        wr(6, 0); wr(3, 0);
        wr(0, 1);
        repeat (3) step();
        wr(1, 100);
        chk("R11 count write", tmr_count, 100);
        wr(2, 0);
        chk("R11 pre write", pre_count, 0);

        // R3 hold
        wr(0, 3);
        repeat (3) step();
        chk("R3 hold count", tmr_count, 0);
        chk("R3 hold pre", pre_count, 0);
        wr(0, 1);
        repeat (10) step();
        chk("R2 resumed", tmr_count, 10);

        finish_up();
    end
endmodule